// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a reference clock into the sample-enable pulse that a UART's receiver and transmitter use for 16x oversampling. The ratio between the reference clock and sixteen times the bit rate is rarely a whole number. The divisor therefore has two parts: an integer count of reference cycles, and a 6-bit fraction measured in 64ths of a cycle. The fraction is added into a 6-bit accumulator at every tick. When that sum overflows, the following tick period is one reference cycle longer. The average spacing is then exactly the integer part plus the fraction divided by 64.

Host software rounds the divisor in 64ths to the nearest value of reference_clock × 64 / (16 × baud). It writes the quotient by 64 into the integer field and the remainder into the fraction field. The reference is either a fixed 16 MHz internal oscillator or the system clock. An external mux merges the two into the single functional clock of this block, and the block drives that mux's select line. Divisor and source may only be changed while the block is disabled. A new divisor that arrives while running is applied only at a tick boundary.

Top module: `baud_frac_gen`

## Requirements
- R1: During reset `tick_o` is 0 and `clk_src_o` is 0, whatever `enable` and the divisor inputs are.
- R2: `tick_o` is never high in a cycle where `enable` is low; dropping `enable` suppresses a tick that was due in that very cycle.
- R3: Every rise of `enable` restarts the count from zero with the accumulator cleared, so the first tick is on the I-th cycle of `enable` high (I = integer divisor).
- R4: An integer divisor of 0 produces no tick at all while enabled.
- R5: With integer divisor I and fraction F (0..63), the k-th tick falls on enabled cycle k·I + floor((k−1)·F/64); each period is I or I+1 cycles.
- R6: Any 64 consecutive tick periods add up to exactly 64·I + F reference cycles.
- R7: A divisor change while enabled does not alter the period in progress; it applies from the period that starts after the next tick.
- R8: `clk_src_o` takes the value of `src_sel` on each clock edge where `enable` is low and holds it while `enable` is high (0 = internal 16 MHz oscillator, 1 = system clock).
- R9: With I = 1 and F = 0, `tick_o` is high on every enabled cycle; with F = 0 the spacing is exactly I.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock from the external source mux |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | UART enable; its rise restarts the tick count |
| src_sel | input | 1 | Requested reference: 0 internal oscillator, 1 system clock |
| div_int_i | input | IW | Integer part of the divisor, in reference cycles |
| div_frac_i | input | FW | Fractional part of the divisor, in 64ths |
| tick_o | output | 1 | One-cycle 16x oversampling pulse |
| clk_src_o | output | 1 | Registered select for the external clock mux |

## Verification
The hardest behaviour to reach is a carry out of the accumulator that lands on a particular tick. Such a carry shows up only as a single extra cycle somewhere in a run of up to 64 periods. The stimulus runs 65 ticks for every fraction value from 0 to 63, at several small integer divisors. It compares each tick's cycle number against the closed-form floor expression, which exercises every carry pattern the 6-bit fraction can produce. A divisor rewrite timed in the middle of a period, and a disable timed on the exact cycle a tick is due, reach the remaining boundary cases.

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int IW = 16,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          src_sel,
  input  logic [IW-1:0] div_int_i,
  input  logic [FW-1:0] div_frac_i,
  output logic          tick_o,
  output logic          clk_src_o
);
  localparam int CW = IW + 1;

  logic [IW-1:0] div_int;
  logic [FW-1:0] div_frac;
  logic [FW-1:0] acc;
  logic          stretch;
  logic [CW-1:0] cnt;
  logic [CW-1:0] plen;
  logic [FW:0]   sum;

  assign plen   = {1'b0, div_int} + CW'(stretch);
  assign sum    = {1'b0, acc} + {1'b0, div_frac};
  assign tick_o = enable && (div_int != '0) && (cnt == plen - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_int   <= '0;
      div_frac  <= '0;
      acc       <= '0;
      stretch   <= 1'b0;
      cnt       <= '0;
      clk_src_o <= 1'b0;
    end else if (!enable) begin
      cnt       <= '0;
      acc       <= '0;
      stretch   <= 1'b0;
      div_int   <= div_int_i;
      div_frac  <= div_frac_i;
      clk_src_o <= src_sel;
    end else if (div_int == '0) begin
      cnt <= '0;
    end else if (tick_o) begin
      cnt      <= '0;
      acc      <= sum[FW-1:0];
      stretch  <= sum[FW];
      div_int  <= div_int_i;
      div_frac <= div_frac_i;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          src_sel,
  input logic [IW-1:0] div_int_i,
  input logic [IW-1:0] div_int,
  input logic          tick_o,
  input logic          clk_src_o
);
  logic [IW+1:0] gap_q;
  logic          zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      zero_q <= 1'b0;
    end else if (!enable) begin
      gap_q  <= '0;
      zero_q <= (div_int_i == '0);
    end else if (tick_o) begin
      gap_q <= '0;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !tick_o);

  assert_period_bounds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> ((gap_q + 1'b1 == {2'b00, div_int}) || (gap_q == {2'b00, div_int})));

  assert_zero_divisor_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && zero_q) |-> !tick_o);

  assert_source_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(clk_src_o));

  assert_source_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (clk_src_o == $past(src_sel)));
endmodule

bind baud_frac_gen baud_frac_gen_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
  .div_int_i(div_int_i), .div_int(div_int), .tick_o(tick_o), .clk_src_o(clk_src_o)
);

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;
  localparam int IW = 16;
  localparam int FW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          src_sel = 1'b0;
  logic [IW-1:0] dint = '0;
  logic [FW-1:0] dfr = '0;
  logic          tick;
  logic          csrc;
  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  baud_frac_gen #(.IW(IW), .FW(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
    .div_int_i(dint), .div_frac_i(dfr), .tick_o(tick), .clk_src_o(csrc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic en);
    @(posedge clk);
    #4 enable = en;
    #4;
  endtask

  task automatic run_cfg(input int I, input int F, input int n);
    int k, cyc, bad, a, e, ex, t1, tn;
    k = 0; cyc = 0; bad = 0; a = 0; e = 0; t1 = 0; tn = 0;
    dint = IW'(I); dfr = FW'(F);
    step(0); step(0);
    while (k < n && cyc < n * (I + 1) + 10) begin
      step(1);
      cyc++;
      if (tick) begin
        k++;
        ex = k * I + ((k - 1) * F) / 64;
        if (cyc != ex && bad == 0) begin bad = 1; a = cyc; e = ex; end
        if (k == 1) t1 = cyc;
        tn = cyc;
      end
    end
    if (k != n && bad == 0) begin bad = 1; a = k; e = n; end
    chk(bad == 0, "R5", a, e);
    if (n == 65) chk(tn - t1 == 64 * I + F, "R6", tn - t1, 64 * I + F);
    step(0);
  endtask

  initial begin
    int cnt, t0, seen;
    int tt[3];
    enable = 1'b1; dint = 16'd3; dfr = 6'd5; src_sel = 1'b1;
    repeat (3) begin
      @(posedge clk); #8;
      chk(tick == 1'b0 && csrc == 1'b0, "R1", {tick, csrc}, 0);
    end
    enable = 1'b0; src_sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R5/R6: full sweep of fractions at small integer divisors
    for (int i = 1; i <= 3; i++)
      for (int f = 0; f < 64; f++) run_cfg(i, f, 65);
    run_cfg(9, 1, 65);
    run_cfg(9, 31, 65);
    run_cfg(9, 63, 65);
    run_cfg(2, 32, 10);

    // R9: divisor 1, no fraction -> every cycle
    dint = 16'd1; dfr = 6'd0; step(0); step(0);
    cnt = 0;
    for (int c = 0; c < 10; c++) begin step(1); if (tick) cnt++; end
    chk(cnt == 10, "R9", cnt, 10);
    step(0);

    // R4: zero integer divisor
    dint = 16'd0; dfr = 6'd17; step(0); step(0);
    cnt = 0;
    for (int c = 0; c < 100; c++) begin step(1); if (tick) cnt++; end
    chk(cnt == 0, "R4", cnt, 0);
    step(0);

    // R2: disable on the cycle a tick is due; R3: restart after re-enable
    dint = 16'd6; dfr = 6'd0; step(0); step(0);
    seen = 0;
    for (int c = 1; c <= 11; c++) begin
      step(1);
      if (tick) seen = seen * 100 + c;
    end
    chk(seen == 6, "R2", seen, 6);
    step(0);
    chk(tick == 1'b0, "R2", tick, 0);
    step(0);
    t0 = 0;
    for (int c = 1; c <= 8; c++) begin
      step(1);
      if (tick && t0 == 0) t0 = c;
    end
    chk(t0 == 6, "R3", t0, 6);
    step(0);

    // R7: divisor rewrite during a period
    dint = 16'd4; dfr = 6'd0; step(0); step(0);
    cnt = 0;
    for (int c = 1; c <= 20; c++) begin
      step(1);
      if (c == 2) dint = 16'd7;
      if (tick && cnt < 3) begin tt[cnt] = c; cnt++; end
    end
    chk(cnt == 3 && tt[0] == 4, "R7", tt[0], 4);
    chk(cnt == 3 && tt[1] == 11, "R7", tt[1], 11);
    chk(cnt == 3 && tt[2] == 18, "R7", tt[2], 18);
    step(0);

    // R8: source select capture and freeze
    src_sel = 1'b1; step(0); step(0);
    chk(csrc == 1'b1, "R8", csrc, 1);
    step(1);
    src_sel = 1'b0;
    for (int c = 0; c < 5; c++) step(1);
    chk(csrc == 1'b1, "R8", csrc, 1);
    step(0);
    chk(csrc == 1'b1, "R8", csrc, 1);
    step(0);
    chk(csrc == 1'b0, "R8", csrc, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule